// File: doc/BRIEF.md
# Qualified Bus Strobe Generator

This block is the glue between a 65xx-style processor with a 24-bit address space and its memory and peripheral chips. It turns the phase-2 clock, the read/write line and the two valid-address flags (data fetch and program fetch) into active-low read and write strobes. A strobe fires only in the phase-2-high half of a cycle in which at least one valid-address flag is set. Dead cycles, where the processor puts out a partly formed address, therefore touch no device.

The chip selects come from the address alone. Any bus master that drives the address lines gets the right select. A direct-memory-access master can take the bus by pulling the bus-enable input low. The strobe outputs then float, and the external master drives its own strobes.

The processor puts the bank byte on the data bus during phase-2 low. A transparent latch holds that byte through phase-2 high, which forms the full 24-bit address. The address map places the ROM in the upper half of every bank. The RAM sits in the lower half of the first `RAM_BANKS` banks. An expansion select covers the rest.

Top module: `bus_strobe_glue`

## Requirements
- R1: The valid-address term is the OR of `vda_i` and `vpa_i`. When both are 0, neither `rd_no` nor `wr_no` goes low in any phase.
- R2: With `be_i`=1 and `rst_ni`=1, `rd_no` is 0 exactly when `phi2_i`=1, `rwb_i`=1 and the valid-address term is 1. Otherwise it is 1.
- R3: With `be_i`=1 and `rst_ni`=1, `wr_no` is 0 exactly when `phi2_i`=1, `rwb_i`=0 and the valid-address term is 1. `rd_no` and `wr_no` are never 0 together.
- R4: While `phi2_i`=0, both strobes are 1 whenever `be_i`=1.
- R5: `strobe_oe_o` equals `be_i`. While `be_i`=0, both strobe outputs are released to high impedance.
- R6: While `phi2_i`=0 and `rst_ni`=1, `addr_o[23:16]` follows `data_i`.
- R7: While `phi2_i`=1, `addr_o[23:16]` holds the value `data_i` had at the rising edge of `phi2_i`, whatever `data_i` does afterwards.
- R8: `addr_o[15:0]` equals `addr_i` at all times.
- R9: `rom_cs_no` is 0 exactly when `addr_i[15]`=1, in any bank and regardless of `vda_i`, `vpa_i`, `rwb_i` and `be_i`. A read at 0xFFFC or 0xFFFD in bank 0 therefore asserts both `rom_cs_no` and `rd_no`.
- R10: `ram_cs_no` is 0 when `addr_i[15]`=0 and the bank is below `RAM_BANKS` (default 1). `ext_cs_no` is 0 when `addr_i[15]`=0 and the bank is `RAM_BANKS` or above. Exactly one select is 0 at any time.
- R11: While `rst_ni`=0, the bank byte is 0 and both strobes are 1, even in a valid phase-2-high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | Phase-2 bus clock |
| rwb_i | input | 1 | 1 for read, 0 for write |
| vda_i | input | 1 | Valid data address flag |
| vpa_i | input | 1 | Valid program address flag |
| be_i | input | 1 | Bus enable. 0 hands the strobes to another master |
| addr_i | input | 16 | Low address lines |
| data_i | input | 8 | Data bus, carrying the bank byte while phase-2 is low |
| rd_no | output | 1 | Active-low read strobe, tri-state |
| wr_no | output | 1 | Active-low write strobe, tri-state |
| strobe_oe_o | output | 1 | 1 while this block drives the strobes |
| addr_o | output | 24 | Full address: bank byte over the low address |
| rom_cs_no | output | 1 | Active-low ROM select |
| ram_cs_no | output | 1 | Active-low RAM select |
| ext_cs_no | output | 1 | Active-low expansion select |

## Verification
The hardest case to reach is the hold of the bank byte through phase-2 high while the data bus carries something else. At the ports, an edge-triggered capture and a correct latch look the same unless the data bus changes after the rising edge. Each stimulated cycle therefore presents one bank byte in the low phase and then drives a different write-data byte shortly after the rising edge. The bus address is sampled in both halves of the cycle.

Dead cycles are mixed into the same stream in both read and write direction. Stretches with the bus released put bank and address patterns on the bus with no valid-address flag and either direction on the read/write line. These stretches show that the selects keep decoding while the strobes are handed off.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xfer_e;

  // active-high selects, inverted at the top boundary
  typedef struct packed {
    logic rom;
    logic ram;
    logic ext;
  } cs_t;

endpackage

// File: rtl/bus_bank_latch.sv
module bus_bank_latch #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);

  logic [BANK_W-1:0] bank_q;

  // open while phi2 low, closed while phi2 high
  always_latch begin
    if (!rst_ni)     bank_q <= '0;
    else if (!phi2_i) bank_q <= data_i;
  end

  assign bank_o = bank_q;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_glue_pkg::*;
(
  input  logic rst_ni,
  input  logic phi2_i,
  input  logic rwb_i,
  input  logic vda_i,
  input  logic vpa_i,
  input  logic be_i,
  output logic rd_no,
  output logic wr_no,
  output logic oe_o
);

  logic  addr_valid;
  xfer_e xfer;
  logic  rd_n;
  logic  wr_n;

  assign addr_valid = vda_i | vpa_i;

  always_comb begin
    xfer = XFER_IDLE;
    if (rst_ni && phi2_i && addr_valid) begin
      xfer = rwb_i ? XFER_READ : XFER_WRITE;
    end
  end

  assign rd_n  = (xfer != XFER_READ);
  assign wr_n  = (xfer != XFER_WRITE);
  assign oe_o  = be_i;
  assign rd_no = be_i ? rd_n : 1'bz;
  assign wr_no = be_i ? wr_n : 1'bz;

endmodule

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
  import bus_glue_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned RAM_BANKS = 1
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cs_t               cs_o
);

  localparam int unsigned ROM_BIT   = ADDR_W - 1;
  localparam int unsigned BANK_SPAN = 1 << BANK_W;

  logic upper_half;
  logic ram_bank;

  assign upper_half = addr_i[ROM_BIT];

  generate
    if (RAM_BANKS >= BANK_SPAN) begin : g_ram_all
      assign ram_bank = 1'b1;
    end else if (RAM_BANKS == 0) begin : g_ram_none
      assign ram_bank = 1'b0;
    end else begin : g_ram_cmp
      localparam logic [BANK_W-1:0] RAM_LIM = BANK_W'(RAM_BANKS);
      assign ram_bank = (bank_i < RAM_LIM);
    end
  endgenerate

  always_comb begin
    cs_o     = '0;
    cs_o.rom = upper_half;
    cs_o.ram = !upper_half && ram_bank;
    cs_o.ext = !upper_half && !ram_bank;
  end

endmodule

// File: rtl/bus_strobe_glue.sv
module bus_strobe_glue
  import bus_glue_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned RAM_BANKS = 1
) (
  input  logic                     rst_ni,
  input  logic                     phi2_i,
  input  logic                     rwb_i,
  input  logic                     vda_i,
  input  logic                     vpa_i,
  input  logic                     be_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BANK_W-1:0]        data_i,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic                     strobe_oe_o,
  output logic [ADDR_W+BANK_W-1:0] addr_o,
  output logic                     rom_cs_no,
  output logic                     ram_cs_no,
  output logic                     ext_cs_no
);

  logic [BANK_W-1:0] bank;
  cs_t               cs;

  bus_bank_latch #(.BANK_W(BANK_W)) u_bank (
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .data_i (data_i),
    .bank_o (bank)
  );

  bus_strobe_gen u_strobe (
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .rwb_i  (rwb_i),
    .vda_i  (vda_i),
    .vpa_i  (vpa_i),
    .be_i   (be_i),
    .rd_no  (rd_no),
    .wr_no  (wr_no),
    .oe_o   (strobe_oe_o)
  );

  bus_addr_decode #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .RAM_BANKS (RAM_BANKS)
  ) u_dec (
    .bank_i (bank),
    .addr_i (addr_i),
    .cs_o   (cs)
  );

  assign addr_o    = {bank, addr_i};
  assign rom_cs_no = ~cs.rom;
  assign ram_cs_no = ~cs.ram;
  assign ext_cs_no = ~cs.ext;

endmodule

// File: rtl/bus_strobe_glue_chk.sv
module bus_strobe_glue_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 8
) (
  input logic                     rst_ni,
  input logic                     phi2_i,
  input logic                     rwb_i,
  input logic                     vda_i,
  input logic                     vpa_i,
  input logic                     be_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [BANK_W-1:0]        data_i,
  input logic                     rd_no,
  input logic                     wr_no,
  input logic                     strobe_oe_o,
  input logic [ADDR_W+BANK_W-1:0] addr_o,
  input logic                     rom_cs_no,
  input logic                     ram_cs_no,
  input logic                     ext_cs_no
);

  // negedge samples the high phase, posedge samples the low phase
  assert_dead_cycle_quiet_R1: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    (be_i && !vda_i && !vpa_i) |-> (rd_no && wr_no));

  assert_read_strobe_R2: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    (be_i && rwb_i && (vda_i || vpa_i)) |-> (!rd_no && wr_no));

  assert_write_strobe_R3: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    (be_i && !rwb_i && (vda_i || vpa_i)) |-> (rd_no && !wr_no));

  assert_no_dual_strobe_R3: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    be_i |-> (rd_no || wr_no));

  assert_low_phase_quiet_R4: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    be_i |-> (rd_no && wr_no));

  assert_release_R5: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    strobe_oe_o == be_i);

  assert_bank_transparent_R6: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    addr_o[ADDR_W+BANK_W-1:ADDR_W] == data_i);

  assert_low_addr_R8: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    addr_o[ADDR_W-1:0] == addr_i);

  assert_rom_map_R9: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    addr_i[ADDR_W-1] |-> !rom_cs_no);

  assert_one_select_R10: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    $countones({rom_cs_no, ram_cs_no, ext_cs_no}) == 2);

endmodule

bind bus_strobe_glue bus_strobe_glue_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .rst_ni      (rst_ni),
  .phi2_i      (phi2_i),
  .rwb_i       (rwb_i),
  .vda_i       (vda_i),
  .vpa_i       (vpa_i),
  .be_i        (be_i),
  .addr_i      (addr_i),
  .data_i      (data_i),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .strobe_oe_o (strobe_oe_o),
  .addr_o      (addr_o),
  .rom_cs_no   (rom_cs_no),
  .ram_cs_no   (ram_cs_no),
  .ext_cs_no   (ext_cs_no)
);

// File: tb/bus_strobe_glue_bench.sv
module bus_strobe_glue_bench;

  localparam int PERIOD    = 20;
  localparam int RAM_BANKS = 1;

  logic        rst_ni = 1'b0;
  logic        phi2   = 1'b0;
  logic        rwb    = 1'b1;
  logic        vda    = 1'b0;
  logic        vpa    = 1'b0;
  logic        be     = 1'b1;
  logic [15:0] addr   = 16'h0000;
  logic [7:0]  data   = 8'h00;
  logic        rd_n, wr_n, oe;
  logic [23:0] addr_o;
  logic        rom_n, ram_n, ext_n;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] ref_bank = 8'h00;

  always #(PERIOD/2) phi2 = ~phi2;

  bus_strobe_glue #(.RAM_BANKS(RAM_BANKS)) u_bus_strobe_glue (
    .rst_ni      (rst_ni),
    .phi2_i      (phi2),
    .rwb_i       (rwb),
    .vda_i       (vda),
    .vpa_i       (vpa),
    .be_i        (be),
    .addr_i      (addr),
    .data_i      (data),
    .rd_no       (rd_n),
    .wr_no       (wr_n),
    .strobe_oe_o (oe),
    .addr_o      (addr_o),
    .rom_cs_no   (rom_n),
    .ram_cs_no   (ram_n),
    .ext_cs_no   (ext_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, evaluated at the sample point
  task automatic compare(input bit high_phase);
    bit va, exp_rd, exp_wr, exp_rom, exp_ram, exp_ext;
    va      = vda | vpa;
    exp_rd  = !(high_phase && rst_ni && va && rwb);
    exp_wr  = !(high_phase && rst_ni && va && !rwb);
    exp_rom = addr[15];
    exp_ram = !addr[15] && (int'(ref_bank) < RAM_BANKS);
    exp_ext = !addr[15] && !(int'(ref_bank) < RAM_BANKS);
    chk("R5", "oe", 32'(oe), 32'(be));
    if (be) begin
      chk(va ? (high_phase ? "R2" : "R4") : "R1", "rd_n", 32'(rd_n), 32'(exp_rd));
      chk(va ? (high_phase ? "R3" : "R4") : "R1", "wr_n", 32'(wr_n), 32'(exp_wr));
    end
    chk(high_phase ? "R7" : "R6", "bank", 32'(addr_o[23:16]), 32'(ref_bank));
    chk("R8", "low addr", 32'(addr_o[15:0]), 32'(addr));
    chk("R9", "rom_cs", 32'(rom_n), 32'(!exp_rom));
    chk("R10", "ram_cs", 32'(ram_n), 32'(!exp_ram));
    chk("R10", "ext_cs", 32'(ext_n), 32'(!exp_ext));
  endtask

  // one full bus cycle: bank on data in low phase, other byte in high phase
  task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] a, input bit rw,
                           input bit d, input bit p, input bit en, input logic [7:0] wdata);
    @(negedge phi2);
    #2;
    data = bank; addr = a; rwb = rw; vda = d; vpa = p; be = en;
    ref_bank = bank;
    #5;
    compare(1'b0);
    @(posedge phi2);
    #2;
    data = wdata;
    #4;
    compare(1'b1);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset holds bank at zero and strobes quiet in a valid high phase
    vda = 1'b1; rwb = 1'b1; be = 1'b1; data = 8'h5A; addr = 16'hFFFC;
    @(posedge phi2);
    #3;
    chk("R11", "rd_n in reset", 32'(rd_n), 32'd1);
    chk("R11", "wr_n in reset", 32'(wr_n), 32'd1);
    chk("R11", "bank in reset", 32'(addr_o[23:16]), 32'd0);
    @(negedge phi2);
    #3;
    chk("R11", "bank in reset low phase", 32'(addr_o[23:16]), 32'd0);
    rst_ni = 1'b1;
    #1;
    chk("R6", "bank opens after reset", 32'(addr_o[23:16]), 32'h5A);

    // R9: reset-vector reads in bank 0
    bus_cycle(8'h00, 16'hFFFC, 1'b1, 1'b1, 1'b0, 1'b1, 8'hEE);
    bus_cycle(8'h00, 16'hFFFD, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    // opcode fetch, RAM write, RAM read
    bus_cycle(8'h00, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA9);
    bus_cycle(8'h00, 16'h0200, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
    bus_cycle(8'h00, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
    // R1: dead cycles in both directions
    bus_cycle(8'h00, 16'hD000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h77);
    bus_cycle(8'h00, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b1, 8'h88);
    // R7/R10: non-zero bank with data bus swapped in the high phase
    bus_cycle(8'h30, 16'hC29C, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    bus_cycle(8'h01, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    bus_cycle(8'hFF, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    bus_cycle(8'h00, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
    // R5: bus released, external master drives addresses
    bus_cycle(8'h00, 16'hFFFE, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12);
    bus_cycle(8'h02, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 8'h34);
    bus_cycle(8'h00, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b0, 8'h56);
    bus_cycle(8'h00, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b1, 8'h56);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      bus_cycle((r[3:0] == 0) ? 8'h00 : r[31:24], r[23:8], r[4], r[5], r[6],
                (r[7:6] != 2'b11), ~r[31:24]);
    end

    // R11: reset during a valid read cycle
    @(negedge phi2);
    #2;
    data = 8'h44; addr = 16'h9000; rwb = 1'b1; vda = 1'b1; be = 1'b1;
    rst_ni = 1'b0;
    @(posedge phi2);
    #3;
    chk("R11", "rd_n on reassert", 32'(rd_n), 32'd1);
    chk("R11", "bank on reassert", 32'(addr_o[23:16]), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule